// File: doc/BRIEF.md
# Set-Associative Page Translation Cache

This block holds recently used page-table entries so that a memory management unit can translate a virtual page number without going to memory. The cache is organised as a number of sets, each with several ways. Every line holds a valid flag, a tag and a full page-table entry. A lookup takes a virtual page number. The low bits of that number select a set, and the remaining upper bits are compared in parallel against the tags of every way in that set. The result is a hit flag and, on a hit, the stored entry, both available in the same cycle.

When a lookup misses, logic outside this block walks the page table in memory. It then installs the fetched entry through the fill port. The fill picks its target way inside the addressed set by these rules, in order. A way that already holds the same page number is reused. Otherwise the lowest-numbered invalid way is taken. Otherwise the set's round-robin pointer chooses the way. A global invalidate empties the whole cache in one cycle, for example after an address-space switch.

The default geometry is 16 sets of 4 ways, a 20-bit page number and 32-bit entries. All of these are parameters.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every line is invalid. Every lookup misses, and the entry output reads zero.
- R2: The set index is page-number bits [IDX_W-1:0] (bits [3:0] by default). The tag is bits [VPN_W-1:IDX_W]. A page number with a matching tag but a different index does not hit.
- R3: A lookup is combinational. It reports a hit, with the stored entry, in the same cycle that the page number is presented, when a valid line in the indexed set has an equal tag. On a miss the entry output is zero.
- R4: A fill becomes visible at the clock edge that samples it. A lookup of the same page number in the fill cycle still sees the old contents.
- R5: When a fill has no matching line and its set has an invalid way, the fill writes the lowest-numbered invalid way. The round-robin pointer is left unchanged.
- R6: When a fill has no matching line and all ways of its set are valid, the fill writes the way named by that set's pointer. The pointer then advances by one, modulo the number of ways. Pointers start at way 0 after reset and after an invalidate.
- R7: A fill whose page number already hits overwrites that same way. No two valid ways of a set ever hold the same tag, and the pointer is left unchanged.
- R8: An invalidate clears every valid flag at the next edge and resets every pointer. It takes priority over a fill in the same cycle, so that fill is dropped.
- R9: Each set has its own pointer and its own lines. A fill or an eviction in one set changes no other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to look up |
| lk_hit | output | 1 | Lookup found a valid matching line |
| lk_pte | output | PTE_W | Stored entry on a hit, zero on a miss |
| fl_en | input | 1 | Install an entry this cycle |
| fl_vpn | input | VPN_W | Page number of the entry being installed |
| fl_pte | input | PTE_W | Entry being installed |
| inv_all | input | 1 | Invalidate every line |

## Verification
Lookup results depend only on the stored state and the current lk_vpn. The bench therefore drives each stimulus just after a falling edge and samples lk_hit and lk_pte one nanosecond later, in that same cycle. Fills and invalidates act at the next rising edge. The bench's reference model applies them right after that edge, so their effect is first compared in the following cycle's lookup, and a same-cycle lookup is checked against the old contents. Victim choice is observed at the ports only: the bench looks up the displaced page number, which must now miss, while the other page numbers must still hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int unsigned TLB_MAX_WAYS = 16;

   // index of the lowest clear bit; all-ones input returns 0
   function automatic int unsigned tlb_first_zero(input logic [TLB_MAX_WAYS-1:0] v);
      int unsigned r;
      r = 0;
      for (int i = TLB_MAX_WAYS - 1; i >= 0; i--) begin
         if (!v[i]) r = i;
      end
      return r;
   endfunction

   // index of the lowest set bit; zero input returns 0
   function automatic int unsigned tlb_first_one(input logic [TLB_MAX_WAYS-1:0] v);
      int unsigned r;
      r = 0;
      for (int i = TLB_MAX_WAYS - 1; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction

endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
   parameter int SETS  = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 16,
   parameter int PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PTE_W-1:0] wr_pte,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [PTE_W-1:0] rd_pte,
   input  logic [IDX_W-1:0] fl_idx,
   input  logic [TAG_W-1:0] fl_tag,
   output logic             fl_hit,
   output logic             fl_valid
);

   logic [SETS-1:0]  vld_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [PTE_W-1:0] pte_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (we) begin
         vld_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (we && !flush) begin
         tag_q[wr_idx] <= wr_tag;
         pte_q[wr_idx] <= wr_pte;
      end
   end

   always_comb begin
      rd_hit   = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
      rd_pte   = pte_q[rd_idx];
      fl_valid = vld_q[fl_idx];
      fl_hit   = fl_valid && (tag_q[fl_idx] == fl_tag);
   end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
   import tlb_pkg::*;
#(
   parameter int WAYS  = 4,
   parameter int SETS  = 16,
   parameter int IDX_W = 4,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic [WAYS-1:0]  valid_vec,
   input  logic [WAYS-1:0]  hit_vec,
   output logic [WAY_W-1:0] way_sel
);

   localparam int PAD = TLB_MAX_WAYS - WAYS;

   logic [WAY_W-1:0] ptr_q [SETS];
   logic             hit_any;
   logic             full;
   logic [WAY_W-1:0] hit_way;
   logic [WAY_W-1:0] free_way;
   logic [TLB_MAX_WAYS-1:0] valid_ext;
   logic [TLB_MAX_WAYS-1:0] hit_ext;

   generate
      if (PAD > 0) begin : g_pad
         assign valid_ext = {{PAD{1'b1}}, valid_vec};
         assign hit_ext   = {{PAD{1'b0}}, hit_vec};
      end else begin : g_nopad
         assign valid_ext = valid_vec;
         assign hit_ext   = hit_vec;
      end
   endgenerate

   always_comb begin
      hit_any  = |hit_vec;
      full     = &valid_vec;
      hit_way  = WAY_W'(tlb_first_one(hit_ext));
      free_way = WAY_W'(tlb_first_zero(valid_ext));
      if (hit_any)    way_sel = hit_way;
      else if (!full) way_sel = free_way;
      else            way_sel = ptr_q[set_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
      end else if (fill_en && !hit_any && full) begin
         ptr_q[set_idx] <= ptr_q[set_idx] + 1'b1;
      end
   end

   // R5
   free_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !hit_any && !full) |-> !valid_vec[way_sel]);

   // R6
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !flush && !hit_any && full) |=> (ptr_q[$past(set_idx)] == $past(way_sel) + 1'b1));

endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
   parameter int WAYS  = 4,
   parameter int SETS  = 16,
   parameter int VPN_W = 20,
   parameter int PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PTE_W-1:0] lk_pte,
   input  logic             fl_en,
   input  logic [VPN_W-1:0] fl_vpn,
   input  logic [PTE_W-1:0] fl_pte,
   input  logic             inv_all
);

   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int WAY_W = $clog2(WAYS);

   generate
      if ((1 << IDX_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two");
      end
      if (WAYS < 2 || WAYS > tlb_pkg::TLB_MAX_WAYS || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("WAYS must be a power of two between 2 and 16");
      end
      if (TAG_W < 1) begin : g_bad_vpn
         $error("VPN_W must exceed the index width");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx, fl_idx;
   logic [TAG_W-1:0] lk_tag, fl_tag;
   logic [WAYS-1:0]  lk_hit_vec, fl_hit_vec, fl_vld_vec;
   logic [PTE_W-1:0] way_pte [WAYS];
   logic [WAY_W-1:0] victim;

   assign lk_idx = lk_vpn[IDX_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
   assign fl_idx = fl_vpn[IDX_W-1:0];
   assign fl_tag = fl_vpn[VPN_W-1:IDX_W];

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         tlb_way #(
            .SETS (SETS),
            .IDX_W(IDX_W),
            .TAG_W(TAG_W),
            .PTE_W(PTE_W)
         ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (inv_all),
            .we      (fl_en && (victim == WAY_W'(w))),
            .wr_idx  (fl_idx),
            .wr_tag  (fl_tag),
            .wr_pte  (fl_pte),
            .rd_idx  (lk_idx),
            .rd_tag  (lk_tag),
            .rd_hit  (lk_hit_vec[w]),
            .rd_pte  (way_pte[w]),
            .fl_idx  (fl_idx),
            .fl_tag  (fl_tag),
            .fl_hit  (fl_hit_vec[w]),
            .fl_valid(fl_vld_vec[w])
         );
      end
   endgenerate

   tlb_victim #(
      .WAYS (WAYS),
      .SETS (SETS),
      .IDX_W(IDX_W),
      .WAY_W(WAY_W)
   ) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (inv_all),
      .fill_en  (fl_en),
      .set_idx  (fl_idx),
      .valid_vec(fl_vld_vec),
      .hit_vec  (fl_hit_vec),
      .way_sel  (victim)
   );

   always_comb begin
      lk_pte = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (lk_hit_vec[w]) lk_pte = lk_pte | way_pte[w];
      end
      lk_hit = |lk_hit_vec;
   end

   // R7
   single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec) && $onehot0(fl_hit_vec));

   // R8
   inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> !lk_hit);

   // R4
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !inv_all) ##1 (lk_vpn == $past(fl_vpn))
      |-> (lk_hit && lk_pte == $past(fl_pte)));

   // R3
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pte == '0));

endmodule

// File: tb/tlb_assoc_bench.sv
module tlb_assoc_bench;

   localparam int WAYS = 4;
   localparam int SETS = 16;
   localparam int VW   = 20;
   localparam int PW   = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_hit;
   logic [PW-1:0] lk_pte;
   logic          fl_en = 1'b0;
   logic [VW-1:0] fl_vpn = '0;
   logic [PW-1:0] fl_pte = '0;
   logic          inv_all = 1'b0;

   int checks = 0;
   int errors = 0;

   bit          m_vld [SETS][WAYS];
   logic [15:0] m_tag [SETS][WAYS];
   logic [PW-1:0] m_pte [SETS][WAYS];
   int          m_ptr [SETS];

   always #2 clk = ~clk;

   tlb_assoc #(.WAYS(WAYS), .SETS(SETS), .VPN_W(VW), .PTE_W(PW)) u_tlb_assoc (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pte(lk_pte),
      .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pte(fl_pte), .inv_all(inv_all)
   );

   function automatic logic [VW-1:0] mk(input int tag, input int idx);
      return {16'(tag), 4'(idx)};
   endfunction

   function automatic int model_way(input logic [VW-1:0] v);
      int s;
      s = int'(v[3:0]);
      for (int w = 0; w < WAYS; w++)
         if (m_vld[s][w] && m_tag[s][w] == v[19:4]) return w;
      return -1;
   endfunction

   task automatic model_reset();
      for (int s = 0; s < SETS; s++) begin
         m_ptr[s] = 0;
         for (int w = 0; w < WAYS; w++) m_vld[s][w] = 1'b0;
      end
   endtask

   task automatic model_fill(input logic [VW-1:0] v, input logic [PW-1:0] p);
      int s, w;
      s = int'(v[3:0]);
      w = model_way(v);
      if (w < 0) begin
         for (int k = WAYS - 1; k >= 0; k--) if (!m_vld[s][k]) w = k;
      end
      if (w < 0) begin
         w = m_ptr[s];
         m_ptr[s] = (m_ptr[s] + 1) % WAYS;
      end
      m_vld[s][w] = 1'b1;
      m_tag[s][w] = v[19:4];
      m_pte[s][w] = p;
   endtask

   task automatic check(input string req);
      int w;
      logic          eh;
      logic [PW-1:0] ep;
      w  = model_way(lk_vpn);
      eh = (w >= 0);
      ep = eh ? m_pte[int'(lk_vpn[3:0])][w] : '0;
      checks++;
      if (lk_hit !== eh || lk_pte !== ep) begin
         errors++;
         $display("FAIL %s vpn=%h actual hit=%b pte=%h expected hit=%b pte=%h",
                  req, lk_vpn, lk_hit, lk_pte, eh, ep);
      end
   endtask

   // one cycle: drive after falling edge, compare lookup, then apply edge to model
   task automatic step(input bit f, input logic [VW-1:0] fv, input logic [PW-1:0] fp,
                       input bit inv, input logic [VW-1:0] lv, input string req);
      @(negedge clk);
      fl_en = f; fl_vpn = fv; fl_pte = fp; inv_all = inv; lk_vpn = lv;
      #1;
      check(req);
      @(posedge clk);
      if (inv) model_reset();
      else if (f) model_fill(fv, fp);
   endtask

   task automatic probe(input logic [VW-1:0] lv, input string req);
      step(1'b0, '0, '0, 1'b0, lv, req);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      probe(mk(0, 0), "R1");
      probe(mk(5, 5), "R1");

      // R5 fill four ways of set 5
      for (int t = 1; t <= 4; t++) step(1'b1, mk(t, 5), 32'hA000 + t, 1'b0, mk(t, 5), "R4");
      for (int t = 1; t <= 4; t++) probe(mk(t, 5), "R5");
      // R2 same tag, other index
      probe(mk(1, 6), "R2");
      // R6 evictions by round robin
      step(1'b1, mk(5, 5), 32'hB005, 1'b0, mk(1, 5), "R6");
      probe(mk(1, 5), "R6");
      probe(mk(5, 5), "R6");
      step(1'b1, mk(6, 5), 32'hB006, 1'b0, mk(2, 5), "R6");
      probe(mk(2, 5), "R6");
      // R7 overwrite existing tag
      step(1'b1, mk(3, 5), 32'hC003, 1'b0, mk(3, 5), "R7");
      probe(mk(3, 5), "R7");
      probe(mk(4, 5), "R7");
      step(1'b1, mk(7, 5), 32'hB007, 1'b0, mk(3, 5), "R6");
      for (int t = 3; t <= 7; t++) probe(mk(t, 5), "R6");
      // R9 other set independent
      step(1'b1, mk(9, 6), 32'hD009, 1'b0, mk(9, 6), "R4");
      probe(mk(9, 6), "R9");
      probe(mk(4, 5), "R9");
      // R8 invalidate beats fill
      step(1'b1, mk(8, 5), 32'hE008, 1'b1, mk(4, 5), "R8");
      probe(mk(8, 5), "R8");
      probe(mk(9, 6), "R8");
      // R6 pointer restarts at way 0 after invalidate
      for (int t = 1; t <= 5; t++) step(1'b1, mk(t, 2), 32'hF000 + t, 1'b0, mk(t, 2), "R6");
      for (int t = 1; t <= 5; t++) probe(mk(t, 2), "R6");

      // R3 constrained random mix
      for (int i = 0; i < 4000; i++) begin
         bit f, inv;
         logic [VW-1:0] fv, lv;
         f   = ($urandom % 3) == 0;
         inv = ($urandom % 97) == 0;
         fv  = mk($urandom % 7, $urandom % 3);
         lv  = (($urandom % 4) == 0) ? fv : mk($urandom % 7, $urandom % 3);
         step(f, fv, $urandom, inv, lv, "R3");
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule